// File: doc/BRIEF.md
# Pileup Tail-Subtraction Stage

One link in a chain of identical stages that untangles overlapping detector pulses in a baseline-corrected sample stream. A stage waits for a sample above a trigger level, then accumulates two running totals over the pulse window: one over the leading cut (the first 20% of the window, rounded up) and one over the whole window. When the leading cut is complete, the stage checks it for early overlap. If the cut total is too large, the stage drops the pulse and stays silent until the input falls back to the trigger level. Otherwise it forms a gain from the cut total and, for every later sample of the window, subtracts a scaled copy of a stored fine-step reference shape. The residual goes to the next stage, so a second pulse buried in the tail becomes visible there.

Samples move through the stage one for one and are never replayed. Before the tail, and outside any pulse, the stage forwards zeros, so the next stage only ever sees what is left after subtraction. The next stage reports a detection on `ds_hit`. If that report arrives during the tail, the energy is the cut total plus the subtracted tail. Otherwise the energy is the whole-window total. Either way the stage then returns to searching. The sub-sample offset that picks the reference phase comes from an external timing lookup on `dt_ofs`.

Back-pressure rules: the input and output streams share one handshake. `out_valid` mirrors `in_valid` and `in_ready` mirrors `out_ready`. A sample is consumed, and its residual delivered, only in a cycle where both are high. In any other cycle the stage's pulse state does not move. `out_data` carries meaning only while `out_valid` is high.

Top module: `pts_stage`

## Requirements
- R1: While reset is held, and right after it, `hit_out` and `egy_valid` are low, and a valid input sample produces a zero `out_data`.
- R2: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle. The pulse state advances only on a transfer, meaning a cycle with `in_valid` and `out_ready` both high.
- R3: In the search state, a transferred sample greater than THRESH (signed) raises `hit_out` for exactly one cycle after that edge. That sample is pulse sample 0.
- R4: `out_data` is zero for samples transferred while searching, during the CUT leading samples of a pulse (CUT = ceil(PULSE_LEN·CUT_PCT/100), 7 by default), and while dead.
- R5: The tail sample i (i = 0..PULSE_LEN−CUT−1) has residual in − S, where S = floor((G·ref[(CUT+i)·RATIO+dt] + 2^(FB−1)) / 2^FB). Here G = P·round(2^FB/A), P is the cut total, A = Σ_{j<CUT} ref[j·RATIO], and dt is the `dt_ofs` value on the last leading transfer. The shape is ref[k] = ⌊k·PEAK/RISE⌋ for k < RISE and ⌊(REF_LEN−k)·PEAK/(REF_LEN−RISE)⌋ otherwise, with REF_LEN = PULSE_LEN·RATIO.
- R6: The residual saturates to the signed DW-bit range, to −2^(DW−1) at the low end and 2^(DW−1)−1 at the high end.
- R7: If `ds_hit` is not seen during the tail, `egy_valid` pulses for one cycle after the last transfer of the window. `egy_value` is then the sum of all PULSE_LEN samples and `egy_interp` is 0.
- R8: If `ds_hit` is high in any cycle of the tail, up to and including the last transfer, the energy is P plus the sum of the S values of all tail samples, and `egy_interp` is 1.
- R9: If P exceeds MAX_PART, the pulse gives no energy and no hit. Zeros are forwarded until a transferred sample is at or below THRESH, which returns the stage to searching.
- R10: After an energy report or a dead period, the next sample above THRESH starts a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Stage accepts the sample |
| in_data | input | DW | Signed baseline-corrected sample |
| out_valid | output | 1 | Residual valid |
| out_ready | input | 1 | Next stage accepts the residual |
| out_data | output | DW | Signed residual toward the next stage |
| dt_ofs | input | DTW | Sub-sample reference phase from the timing lookup |
| hit_out | output | 1 | One-cycle pulse-detected flag toward the upstream stage |
| ds_hit | input | 1 | Detection flag from the downstream stage |
| egy_valid | output | 1 | Energy result strobe |
| egy_value | output | EW | Signed pulse energy |
| egy_interp | output | 1 | Energy used the cut total plus the subtracted tail |

## Verification
The assertions take for granted that the stage comes out of an applied reset, and that `ds_hit` only sets a flag and never moves the pulse state, so state changes are tied to transfers alone. The stimulus keeps samples inside the signed DW-bit range, drives `dt_ofs` over its full 0..RATIO−1 span, and applies random stalls on both sides of the handshake. Pulses are drawn from the reference shape at random amplitudes and phases. Directed pulses push the residual past both saturation limits, push the cut total past MAX_PART, and place the downstream flag inside the tail.

// File: rtl/pts_pkg.sv
package pts_pkg;

  typedef enum logic [1:0] {ST_SEEK, ST_LEAD, ST_TAIL, ST_DEAD} pts_state_e;

  // Fine-step reference shape: linear rise over RISE steps, linear fall to zero at LEN.
  function automatic int ref_shape(int k, int len, int rise, int peak);
    if (k < 0 || k >= len) return 0;
    if (k < rise) return (k * peak) / rise;
    return ((len - k) * peak) / (len - rise);
  endfunction

  // Area of the reference over the leading cut, sampled at the coarse step.
  function automatic int lead_area(int cut, int ratio, int len, int rise, int peak);
    int acc;
    acc = 0;
    for (int j = 0; j < cut; j++) acc += ref_shape(j * ratio, len, rise, peak);
    return acc;
  endfunction

endpackage

// File: rtl/pts_ref_rom.sv
module pts_ref_rom #(
  parameter int REF_LEN = 128,
  parameter int RISE    = 12,
  parameter int PEAK    = 1000,
  parameter int RW      = 10,
  parameter int AW      = 7
) (
  input  logic [AW-1:0] addr,
  output logic [RW-1:0] data
);
  logic [RW-1:0] tbl [REF_LEN];

  for (genvar g = 0; g < REF_LEN; g++) begin : g_ent
    assign tbl[g] = RW'(pts_pkg::ref_shape(g, REF_LEN, RISE, PEAK));
  end

  assign data = tbl[addr];
endmodule

// File: rtl/pts_tail_scale.sv
module pts_tail_scale #(
  parameter int DW = 12,
  parameter int RW = 10,
  parameter int GW = 44,
  parameter int FB = 24,
  parameter int SW = 20
) (
  input  logic signed [DW-1:0] smp,
  input  logic        [RW-1:0] refv,
  input  logic signed [GW-1:0] gain,
  output logic signed [SW-1:0] sub,
  output logic signed [DW-1:0] resid
);
  localparam logic signed [63:0] HALF = 64'sd1 <<< (FB - 1);
  localparam logic signed [63:0] HI   = (64'sd1 <<< (DW - 1)) - 64'sd1;
  localparam logic signed [63:0] LO   = -(64'sd1 <<< (DW - 1));

  logic signed [63:0] prod, scaled, diff;

  always_comb begin
    prod   = 64'(gain) * 64'($signed({1'b0, refv}));
    scaled = (prod + HALF) >>> FB;
    diff   = 64'(smp) - scaled;
    sub    = SW'(scaled);
    if (diff > HI)      resid = DW'(HI);
    else if (diff < LO) resid = DW'(LO);
    else                resid = DW'(diff);
  end
endmodule

// File: rtl/pts_stage.sv
module pts_stage #(
  parameter int DW        = 12,
  parameter int PULSE_LEN = 32,
  parameter int CUT_PCT   = 20,
  parameter int RATIO     = 4,
  parameter int RISE      = 12,
  parameter int PEAK      = 1000,
  parameter int THRESH    = 40,
  parameter int MAX_PART  = 9000,
  parameter int FB        = 24,
  localparam int DTW      = (RATIO > 1) ? $clog2(RATIO) : 1,
  localparam int EW       = DW + $clog2(PULSE_LEN) + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_data,
  input  logic [DTW-1:0]       dt_ofs,
  output logic                 hit_out,
  input  logic                 ds_hit,
  output logic                 egy_valid,
  output logic signed [EW-1:0] egy_value,
  output logic                 egy_interp
);
  import pts_pkg::*;

  localparam int CUT      = (PULSE_LEN * CUT_PCT + 99) / 100;
  localparam int TAIL_LEN = PULSE_LEN - CUT;
  localparam int REF_LEN  = PULSE_LEN * RATIO;
  localparam int AW       = $clog2(REF_LEN);
  localparam int RW       = $clog2(PEAK + 1);
  localparam int CW       = $clog2(PULSE_LEN + 1);
  localparam int GW       = EW + FB;
  localparam int AREA     = lead_area(CUT, RATIO, REF_LEN, RISE, PEAK);
  localparam longint INV  = ((64'sd1 <<< FB) + longint'(AREA / 2)) / longint'(AREA);
  localparam logic signed [DW-1:0] THR  = DW'(THRESH);
  localparam logic signed [EW-1:0] MAXP = EW'(MAX_PART);

  pts_state_e           st;
  logic [CW-1:0]        cnt, tcnt;
  logic [DTW-1:0]       dt_q;
  logic signed [EW-1:0] psum, fsum, tail_e;
  logic signed [EW-1:0] psum_nx, fsum_nx, smp_ext;
  logic signed [GW-1:0] gain;
  logic                 flag;
  logic                 fire;
  logic [AW-1:0]        addr;
  logic [RW-1:0]        refv;
  logic signed [EW-1:0] sub;
  logic signed [DW-1:0] resid;

  assign fire      = in_valid & out_ready;
  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign smp_ext   = EW'(in_data);
  assign psum_nx   = psum + smp_ext;
  assign fsum_nx   = fsum + smp_ext;
  assign addr      = AW'(CUT * RATIO + RATIO * int'(tcnt) + int'(dt_q));
  assign out_data  = (st == ST_TAIL) ? resid : '0;

  pts_ref_rom #(.REF_LEN(REF_LEN), .RISE(RISE), .PEAK(PEAK), .RW(RW), .AW(AW)) u_rom (
    .addr(addr), .data(refv)
  );

  pts_tail_scale #(.DW(DW), .RW(RW), .GW(GW), .FB(FB), .SW(EW)) u_scale (
    .smp(in_data), .refv(refv), .gain(gain), .sub(sub), .resid(resid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_SEEK;
      cnt        <= '0;
      tcnt       <= '0;
      dt_q       <= '0;
      psum       <= '0;
      fsum       <= '0;
      tail_e     <= '0;
      gain       <= '0;
      flag       <= 1'b0;
      hit_out    <= 1'b0;
      egy_valid  <= 1'b0;
      egy_value  <= '0;
      egy_interp <= 1'b0;
    end else begin
      hit_out   <= 1'b0;
      egy_valid <= 1'b0;
      if (st == ST_TAIL && ds_hit) flag <= 1'b1;
      if (fire) begin
        unique case (st)
          ST_SEEK: if (in_data > THR) begin
            hit_out <= 1'b1;
            psum    <= smp_ext;
            fsum    <= smp_ext;
            cnt     <= CW'(1);
            st      <= ST_LEAD;
          end
          ST_LEAD: begin
            psum <= psum_nx;
            fsum <= fsum_nx;
            cnt  <= cnt + CW'(1);
            if (cnt == CW'(CUT - 1)) begin
              if (psum_nx > MAXP) begin
                st <= ST_DEAD;
              end else begin
                gain   <= GW'(psum_nx) * GW'(INV);
                dt_q   <= dt_ofs;
                tcnt   <= '0;
                tail_e <= '0;
                flag   <= 1'b0;
                st     <= ST_TAIL;
              end
            end
          end
          ST_TAIL: begin
            fsum   <= fsum_nx;
            tail_e <= tail_e + sub;
            tcnt   <= tcnt + CW'(1);
            if (tcnt == CW'(TAIL_LEN - 1)) begin
              egy_valid <= 1'b1;
              if (flag || ds_hit) begin
                egy_value  <= psum + tail_e + sub;
                egy_interp <= 1'b1;
              end else begin
                egy_value  <= fsum_nx;
                egy_interp <= 1'b0;
              end
              st <= ST_SEEK;
            end
          end
          ST_DEAD: if (in_data <= THR) st <= ST_SEEK;
          default: st <= ST_SEEK;
        endcase
      end
    end
  end
endmodule

// File: rtl/pts_stage_chk.sv
module pts_stage_chk (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               out_ready,
  input pts_pkg::pts_state_e st,
  input logic               hit_out,
  input logic               egy_valid
);
  import pts_pkg::*;

  AST_HIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_out |=> !hit_out); // R3
  AST_HIT_FROM_SEEK: assert property (@(posedge clk) disable iff (!rst_n)
    hit_out |-> ($past(st) == ST_SEEK && st == ST_LEAD)); // R3
  AST_EGY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    egy_valid |=> !egy_valid); // R7
  AST_EGY_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    egy_valid |-> ($past(st) == ST_TAIL && st == ST_SEEK)); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && out_ready) |=> $stable(st)); // R2
  AST_DEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEAD) |-> (!egy_valid && !hit_out)); // R9
endmodule

bind pts_stage pts_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
  .st(st), .hit_out(hit_out), .egy_valid(egy_valid)
);

// File: tb/test_pts_stage.sv
module test_pts_stage;
  localparam int DW = 12, PL = 32, CUT = 7, RT = 4, RISE = 12, PEAK = 1000;
  localparam int THR = 40, MAXP = 9000, FB = 24, RLEN = PL * RT, EW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, ds_hit = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic [1:0] dt_ofs = '0;
  logic in_ready, out_valid, hit_out, egy_valid, egy_interp;
  logic signed [DW-1:0] out_data;
  logic signed [EW-1:0] egy_value;

  always #2 clk = ~clk;

  pts_stage i_pts_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .dt_ofs(dt_ofs),
    .hit_out(hit_out), .ds_hit(ds_hit), .egy_valid(egy_valid), .egy_value(egy_value),
    .egy_interp(egy_interp)
  );

  int checks = 0, fails = 0, n_hit = 0, n_egy = 0, sat_lo = 0, sat_hi = 0, n_interp = 0;
  bit done = 0;
  int stall_pct = 0;
  longint inv;

  int mst = 0, mcnt = 0, mtcnt = 0, mdt = 0;
  longint mpsum = 0, mfsum = 0, mtail = 0, mgain = 0, m_egy = 0;
  bit mflag = 0, m_hit = 0, m_ev = 0, m_int = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic longint refv(int k);
    if (k < 0 || k >= RLEN) return 0;
    if (k < RISE) return longint'((k * PEAK) / RISE);
    return longint'(((RLEN - k) * PEAK) / (RLEN - RISE));
  endfunction

  function automatic longint msub();
    longint p;
    p = mgain * refv((CUT + mtcnt) * RT + mdt);
    return (p + (64'sd1 <<< (FB - 1))) >>> FB;
  endfunction

  function automatic longint sat(longint v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic model_step(bit f, longint d, bit dh, int dt);
    longint s;
    m_hit = 0; m_ev = 0;
    if (mst == 2 && dh) mflag = 1;
    if (!f) return;
    case (mst)
      0: if (d > THR) begin m_hit = 1; mpsum = d; mfsum = d; mcnt = 1; mst = 1; end
      1: begin
        mpsum += d; mfsum += d;
        if (mcnt == CUT - 1) begin
          if (mpsum > MAXP) mst = 3;
          else begin mgain = mpsum * inv; mdt = dt; mtcnt = 0; mtail = 0; mflag = 0; mst = 2; end
        end
        mcnt++;
      end
      2: begin
        s = msub();
        mfsum += d;
        if (mtcnt == PL - CUT - 1) begin
          m_ev = 1;
          if (mflag) begin m_egy = mpsum + mtail + s; m_int = 1; end
          else begin m_egy = mfsum; m_int = 0; end
          mst = 0;
        end
        mtail += s; mtcnt++;
      end
      default: if (d <= THR) mst = 0;
    endcase
  endtask

  task automatic step(bit v, longint d, bit r, bit dh, int dt);
    longint e;
    in_valid = v; in_data = DW'(d); out_ready = r; ds_hit = dh; dt_ofs = 2'(dt);
    #1;
    chk("R2 out_valid", longint'(out_valid), longint'(v));
    chk("R2 in_ready", longint'(in_ready), longint'(r));
    if (v) begin
      e = (mst == 2) ? sat(d - msub()) : 0;
      chk(mst == 2 ? "R5 residual" : "R4 zero fwd", longint'(out_data), e);
      if (mst == 2 && out_data == -2048) sat_lo++;
      if (mst == 2 && out_data == 2047) sat_hi++;
    end
    model_step(v && r, d, dh, dt);
    @(posedge clk); @(negedge clk);
    chk("R3 hit_out", longint'(hit_out), longint'(m_hit));
    chk(m_int ? "R8 egy_valid" : "R7 egy_valid", longint'(egy_valid), longint'(m_ev));
    if (hit_out) n_hit++;
    if (egy_valid) n_egy++;
    if (m_ev) begin
      chk(m_int ? "R8 energy" : "R7 energy", longint'(egy_value), m_egy);
      chk(m_int ? "R8 interp" : "R7 interp", longint'(egy_interp), longint'(m_int));
      if (egy_interp) n_interp++;
    end
  endtask

  task automatic send(longint d, bit dh, int dt);
    bit v, r;
    do begin
      v = ($urandom % 100) >= stall_pct;
      r = ($urandom % 100) >= stall_pct;
      step(v, d, r, dh, dt);
    end while (!(v && r));
  endtask

  task automatic pulse(int amp, int ph, int dt, int hit_at, int gap);
    longint d;
    for (int i = 0; i < PL; i++) begin
      d = (longint'(amp) * refv(i * RT + ph)) / 1000 + longint'($urandom % 7) - 3;
      if (i == 0 && d <= THR) d = THR + 5;
      send(sat(d), i == hit_at, dt);
    end
    for (int i = 0; i < gap; i++) send(longint'($urandom % 7) - 3, 0, dt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    longint area;
    int h0, e0;
    void'($urandom(1234));
    area = 0;
    for (int j = 0; j < CUT; j++) area += refv(j * RT);
    inv = ((64'sd1 <<< FB) + area / 2) / area;

    // R1: reset state
    in_valid = 1; out_ready = 1; in_data = 12'sd1000;
    repeat (3) @(negedge clk);
    chk("R1 hit_out in reset", longint'(hit_out), 0);
    chk("R1 egy_valid in reset", longint'(egy_valid), 0);
    chk("R1 out_data in reset", longint'(out_data), 0);
    rst_n = 1'b1;
    in_valid = 0;
    @(negedge clk);
    chk("R1 hit_out after reset", longint'(hit_out), 0);
    chk("R1 egy_valid after reset", longint'(egy_valid), 0);

    // R7: isolated pulse, no downstream report
    pulse(800, 2, 1, -1, 4);
    // R8: downstream report inside the tail
    pulse(900, 1, 3, 15, 4);
    chk("R8 interp energy seen", longint'(n_interp), 1);

    // R6: low saturation
    send(500, 0, 0);
    for (int i = 0; i < CUT - 1; i++) send(1200, 0, 0);
    for (int i = 0; i < PL - CUT; i++) send(-2000, 0, 0);
    chk("R6 low saturation seen", longint'(sat_lo > 0), 1);
    // R6: high saturation via negative cut total
    send(500, 0, 2);
    for (int i = 0; i < CUT - 1; i++) send(-2000, 0, 2);
    for (int i = 0; i < PL - CUT; i++) send(2000, 0, 2);
    chk("R6 high saturation seen", longint'(sat_hi > 0), 1);
    send(0, 0, 0);

    // R9: peak overlap -> dead until baseline; R10: recovery
    h0 = n_hit; e0 = n_egy;
    for (int i = 0; i < CUT; i++) send(1500, 0, 0);
    for (int i = 0; i < 6; i++) send(1000, 0, 0);
    chk("R9 no energy while dead", longint'(n_egy - e0), 0);
    chk("R9 no extra hit while dead", longint'(n_hit - h0), 1);
    send(0, 0, 0);
    pulse(700, 3, 0, -1, 2);
    chk("R10 new pulse detected", longint'(n_hit - h0), 2);
    chk("R10 new pulse energy", longint'(n_egy - e0), 1);

    // R2: random stalls with random pulses, downstream reports and back-to-back trains
    stall_pct = 30;
    for (int p = 0; p < 300; p++) begin
      pulse(200 + int'($urandom % 1900), 1 + int'($urandom % 3), int'($urandom % 4),
            ($urandom % 2) ? int'(CUT + 1 + $urandom % 20) : -1, int'($urandom % 6));
    end
    stall_pct = 0;
    chk("R3 hits observed", longint'(n_hit > 200), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule